// File: doc/BRIEF.md
# Windowed Phase Stability Accumulator

This block watches how stable a local clock is while a synchronisation servo works. It takes a stream of signed phase-offset samples. A valid strobe marks each sample, and the samples arrive at a fixed interval of one per second. For every three consecutive samples it forms the second difference `x[k] - 2*x[k-1] + x[k-2]` and squares it. It keeps a running total of these squared terms over a sliding window of the most recent `WIN` samples, which is 100 by default. Watching that total over time shows the stability figure settling, for example after power-up.

The total is maintained incrementally. Each accepted sample adds the newest squared term and subtracts the term that leaves the window. The window holds `WIN-2` squared terms in a circular store. Software reads the raw total and turns it into a variance by dividing by `2*(WIN-2)*tau^2`, and takes the square root if a deviation is wanted. The input samples must be equally spaced for that result to be meaningful. A synchronous clear empties the window and starts the fill again.

Top module: `allan_window_acc`

## Requirements
- R1: After reset, `out_valid` is 0 and `out_sum` is 0.
- R2: After reset or clear, `out_valid` stays 0 for the first `WIN-1` accepted samples (99 by default). It first goes high in the cycle after the `WIN`-th accepted sample.
- R3: Once the window is full, `out_valid` is high for exactly one cycle after each accepted sample. In any other cycle it is low.
- R4: Whenever `out_valid` is high, `out_sum` equals the sum of `(x[k] - 2*x[k-1] + x[k-2])^2` over the most recent `WIN` accepted samples, treated as signed two's-complement values. With `WIN` samples there are `WIN-2` such terms.
- R5: Full-scale inputs (alternating +2^31-1 and -2^31) give an exact, non-wrapping `out_sum`. The second difference is formed at `PHASE_W+2` bits and the total is held at `SUM_W` bits.
- R6: While `clr` is high, the sample offered in that cycle is dropped and the window is emptied. In the next cycle `out_valid` is 0 and `out_sum` is 0.
- R7: In a cycle where `in_valid` is low, the window does not change. `out_sum` holds its value and `out_valid` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous window clear; takes priority over `in_valid` |
| in_valid | input | 1 | Marks a phase sample on `in_phase` |
| in_phase | input | PHASE_W (32) | Signed phase offset sample |
| out_valid | output | 1 | One-cycle pulse per accepted sample once the window is full |
| out_sum | output | SUM_W (75) | Windowed sum of squared second differences |

## Verification
A wrong write pointer or a stale entry in the circular store does not show while the window fills. It shows in the first `out_sum` reported after the store wraps. From then on it shows on every pulse, as a total that drifts away from the true windowed sum. A fill counter that is off by one shows as `out_valid` rising one sample early or late. A clear that leaves terms behind shows as a wrong total exactly `WIN` samples after the clear. Truncation in the difference or the square shows only under full-scale input, so the bench drives full-scale patterns for more than a whole window.

// File: rtl/allan_window_acc.sv
module allan_window_acc #(
  parameter int PHASE_W = 32,
  parameter int WIN     = 100,
  localparam int TERMS  = WIN - 2,
  localparam int DIFF_W = PHASE_W + 2,
  localparam int SQ_W   = 2 * DIFF_W - 1,
  localparam int SUM_W  = SQ_W + $clog2(TERMS) + 1,
  localparam int PTR_W  = $clog2(TERMS),
  localparam int CNT_W  = $clog2(TERMS + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      in_valid,
  input  logic signed [PHASE_W-1:0] in_phase,
  output logic                      out_valid,
  output logic        [SUM_W-1:0]   out_sum
);

  localparam logic [CNT_W-1:0] FULL  = CNT_W'(TERMS);
  localparam logic [PTR_W-1:0] LAST  = PTR_W'(TERMS - 1);

  logic signed [PHASE_W-1:0]  x1, x2;
  logic        [1:0]          seen;
  logic        [CNT_W-1:0]    terms;
  logic        [PTR_W-1:0]    wp;
  logic        [SQ_W-1:0]     ring [TERMS];

  logic                       take, emit;
  logic signed [DIFF_W-1:0]   d2;
  logic signed [2*DIFF_W-1:0] d2_sq;
  logic        [SQ_W-1:0]     sq;
  logic        [CNT_W-1:0]    terms_nx;

  assign take  = in_valid && !clr;
  assign emit  = take && (seen == 2'd2);
  assign d2    = DIFF_W'(in_phase) - (DIFF_W'(x1) <<< 1) + DIFF_W'(x2);
  assign d2_sq = d2 * d2;
  assign sq    = d2_sq[SQ_W-1:0];
  assign terms_nx = (terms == FULL) ? FULL : terms + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x1 <= '0;
      x2 <= '0;
      seen <= '0;
    end else if (clr) begin
      seen <= '0;
    end else if (take) begin
      x1 <= in_phase;
      x2 <= x1;
      if (seen != 2'd2) seen <= seen + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TERMS; i++) ring[i] <= '0;
      wp <= '0;
      terms <= '0;
      out_sum <= '0;
      out_valid <= 1'b0;
    end else if (clr) begin
      for (int i = 0; i < TERMS; i++) ring[i] <= '0;
      wp <= '0;
      terms <= '0;
      out_sum <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= emit && (terms_nx == FULL);
      if (emit) begin
        ring[wp] <= sq;
        wp <= (wp == LAST) ? '0 : wp + 1'b1;
        terms <= terms_nx;
        out_sum <= out_sum + SUM_W'(sq) - SUM_W'(ring[wp]);
      end
    end
  end

endmodule

// File: rtl/allan_window_acc_chk.sv
module allan_window_acc_chk #(
  parameter int PHASE_W = 32,
  parameter int WIN     = 100,
  parameter int SUM_W   = 75
) (
  input logic               clk,
  input logic               rst_n,
  input logic               clr,
  input logic               in_valid,
  input logic               out_valid,
  input logic [SUM_W-1:0]   out_sum
);

  localparam int CW = $clog2(WIN + 1);
  logic [CW-1:0] acc_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_cnt <= '0;
    else if (clr) acc_cnt <= '0;
    else if (in_valid && acc_cnt != CW'(WIN)) acc_cnt <= acc_cnt + 1'b1;
  end

  AST_FILL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (acc_cnt == CW'(WIN)));                                        // R2
  AST_FILL_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !clr && acc_cnt >= CW'(WIN - 1)) |=> out_valid);                // R3
  AST_PULSE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid && !clr));                                      // R3
  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!out_valid && out_sum == '0));                                      // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !clr) |=> ($stable(out_sum) && !out_valid));                   // R7

endmodule

bind allan_window_acc allan_window_acc_chk #(
  .PHASE_W(PHASE_W), .WIN(WIN), .SUM_W(SUM_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
  .out_valid(out_valid), .out_sum(out_sum)
);

// File: tb/test_allan_window_acc.sv
module test_allan_window_acc;
  localparam int PHASE_W = 32;
  localparam int WIN     = 100;
  localparam int SUM_W   = 75;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic in_valid = 1'b0;
  logic signed [PHASE_W-1:0] in_phase = '0;
  logic out_valid;
  logic [SUM_W-1:0] out_sum;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic signed [63:0] hist [$];

  always #5 clk = ~clk;

  allan_window_acc #(.PHASE_W(PHASE_W), .WIN(WIN)) i_allan_window_acc (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
    .in_phase(in_phase), .out_valid(out_valid), .out_sum(out_sum)
  );

  function automatic logic [127:0] model_sum();
    logic signed [127:0] dd;
    logic [127:0] s = '0;
    for (int i = 0; i + 2 < hist.size(); i++) begin
      dd = hist[i+2] - 2 * hist[i+1] + hist[i];
      s += 128'(dd * dd);
    end
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic signed [PHASE_W-1:0] v, input bit with_clr, input string req);
    bit exp_v;
    in_valid = 1'b1; in_phase = v; clr = with_clr;
    @(negedge clk);
    in_valid = 1'b0; clr = 1'b0;
    if (with_clr) hist.delete();
    else begin
      hist.push_back(64'(v));
      if (hist.size() > WIN) void'(hist.pop_front());
    end
    exp_v = !with_clr && hist.size() == WIN;
    check(out_valid == exp_v, req, 128'(out_valid), 128'(exp_v));
    if (exp_v && out_valid)
      check(128'(out_sum) == model_sum(), "R4/R5 sum", 128'(out_sum), model_sum());
    if (with_clr) check(out_sum == '0, "R6 cleared sum", 128'(out_sum), 128'd0);
  endtask

  initial begin
    logic [SUM_W-1:0] held;
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 valid", 128'(out_valid), 0);
    check(out_sum == '0, "R1 sum", 128'(out_sum), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < WIN - 1; k++) send(PHASE_W'(int'($urandom_range(2000)) - 1000), 0, "R2 fill");
    send(32'sd5, 0, "R2 first valid");
    for (int k = 0; k < 150; k++) send(PHASE_W'(int'($urandom_range(200000)) - 100000), 0, "R3 steady");

    held = out_sum;
    repeat (4) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R7 idle valid", 128'(out_valid), 0);
      check(out_sum == held, "R7 idle hold", 128'(out_sum), 128'(held));
    end
    for (int k = 0; k < 20; k++) begin
      send(PHASE_W'($urandom), 0, "R3 gapped");
      repeat (k % 3) @(negedge clk);
    end

    send(32'sd123456, 1, "R6 clear drops sample");
    for (int k = 0; k < WIN - 1; k++) send(PHASE_W'(k * k - 3000), 0, "R6 refill");
    send(-32'sd77, 0, "R6 refill complete");
    send(32'sd1, 0, "R4 after refill");

    for (int k = 0; k < WIN + 30; k++)
      send((k % 2 == 0) ? 32'sh7fffffff : 32'sh80000000, 0, "R5 full scale");
    for (int k = 0; k < 60; k++) send(PHASE_W'($urandom), 0, "R5 random wide");
    for (int k = 0; k < WIN + 5; k++) send(32'sh80000000, 0, "R4 constant");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule